// File: doc/BRIEF.md
# Store Commit Buffer

This block holds stores that have already been written into a write-through first-level cache. They wait here until they can be forwarded to the second-level cache. Each store enters with the sequence tag of the instruction that issued it and starts out pending. A pending entry cannot leave. When the retirement logic reports that the instruction finished cleanly, the entry becomes committed. Committed entries are sent toward the second-level cache oldest first, over a valid/ready port, one per cycle.

When an instruction is found to have a permanent fault, a squash names its tag. Every still-pending entry from that instruction or any younger one is then discarded, so none of that data ever leaves the first level. Sometimes an instruction is retried after a transient disagreement and its store executes a second time. In that case the existing pending entry is refreshed in place rather than duplicated. Sequence tags wrap around, so age is judged modulo 2^TAG_W over a window of half the tag space. The entry count must be a power of two and at least two.

Top module: `store_commit_buffer`

## Requirements
- R1: After reset the buffer is empty: drain_valid is 0 and alloc_ready is 1.
- R2: A store is accepted on a cycle with alloc_valid and alloc_ready both high, and it enters in the pending state. A pending entry is never offered on the drain port, and it also blocks every entry behind it.
- R3: retire_valid with retire_tag equal to a pending entry's tag commits that entry. The entry can then drain from the next cycle on. A retire that names the tag being allocated in the same cycle commits the new entry directly.
- R4: drain_valid is high exactly when the oldest held entry is committed. Entries leave in allocation order, one per cycle on which drain_valid and drain_ready are both high. While drain_ready is low, drain_tag, drain_addr and drain_data hold steady.
- R5: While DEPTH entries are held, alloc_ready is low, and a new store waits. The exception is a store whose tag matches a pending entry, which is still accepted.
- R6: squash_valid discards every pending entry whose tag is at or younger than squash_tag. A tag t counts as at or younger when (t - squash_tag) mod 2^TAG_W < 2^(TAG_W-1). Committed entries are kept. alloc_ready is low on a squash cycle.
- R7: A store whose tag equals that of a pending entry overwrites that entry's address and data and adds no new entry.
- R8: A retire whose tag matches no pending entry, such as one that arrives for a squashed instruction, changes nothing on the drain port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A store is offered |
| alloc_ready | output | 1 | The buffer can take the offered store |
| alloc_tag | input | TAG_W | Sequence tag of the storing instruction |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| retire_valid | input | 1 | An instruction retired cleanly |
| retire_tag | input | TAG_W | Tag of the retired instruction |
| squash_valid | input | 1 | An instruction has a permanent fault |
| squash_tag | input | TAG_W | Tag of the faulted instruction |
| drain_valid | output | 1 | Oldest entry is committed and offered |
| drain_ready | input | 1 | Second-level cache accepts the offered entry |
| drain_tag | output | TAG_W | Tag of the offered entry |
| drain_addr | output | ADDR_W | Address of the offered entry |
| drain_data | output | DATA_W | Data of the offered entry |

## Verification
The checker enforces several rules on every cycle:
- the offered drain entry holds steady under backpressure;
- occupancy never passes DEPTH, and a store taken while full adds no entry;
- the cycle after a squash, no pending entry at or younger than the squashed tag remains;
- no two pending entries ever share a tag.

Other properties can only be shown by the bench's scenarios, because they depend on which values reach the drain port:
- drain order;
- that squashed data never appears even after a late retire;
- the wrap-around age comparison;
- the refreshed data of a retried store;
- a retire that lands in the same cycle as its allocation.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned SB_DEPTH_DEF  = 8;
    localparam int unsigned SB_TAG_W_DEF  = 6;
    localparam int unsigned SB_ADDR_W_DEF = 40;
    localparam int unsigned SB_DATA_W_DEF = 64;

    // Life cycle of one buffer slot.
    typedef enum logic [1:0] {
        SB_FREE = 2'd0,
        SB_PEND = 2'd1,
        SB_DONE = 2'd2
    } sb_state_e;

    // True when tag is the same age as base or younger, on a ring of 2^w tags.
    function automatic logic tag_not_older(input logic [31:0] tag,
                                           input logic [31:0] base,
                                           input int unsigned w);
        logic [31:0] diff;
        diff = tag - base;
        return diff[w-1] == 1'b0;
    endfunction

endpackage

// File: rtl/sb_tag_match.sv
module sb_tag_match
    import sb_pkg::*;
#(
    parameter int DEPTH = SB_DEPTH_DEF,
    parameter int TAG_W = SB_TAG_W_DEF,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]            pend_vec,
    input  logic [DEPTH-1:0][TAG_W-1:0] ent_tag,
    input  logic                        retire_valid,
    input  logic [TAG_W-1:0]            retire_tag,
    input  logic                        squash_valid,
    input  logic [TAG_W-1:0]            squash_tag,
    input  logic [TAG_W-1:0]            alloc_tag,
    output logic [DEPTH-1:0]            kill_mask,
    output logic [DEPTH-1:0]            commit_mask,
    output logic [DEPTH-1:0]            dup_mask,
    output logic                        dup_hit,
    output logic [IDX_W-1:0]            dup_idx,
    output logic [CNT_W-1:0]            kill_cnt
);

    // Three comparators per slot: squash age, retire match, retry match.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            kill_mask[i]   = pend_vec[i] && squash_valid &&
                             tag_not_older(32'(ent_tag[i]), 32'(squash_tag), TAG_W);
            commit_mask[i] = pend_vec[i] && retire_valid &&
                             (ent_tag[i] == retire_tag) && !kill_mask[i];
            dup_mask[i]    = pend_vec[i] && (ent_tag[i] == alloc_tag);
        end
    end

    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (dup_mask[i]) dup_idx = IDX_W'(i);
        end
    end

    assign dup_hit  = |dup_mask;
    assign kill_cnt = CNT_W'($countones(kill_mask));

endmodule

// File: rtl/sb_ring_ptr.sv
module sb_ring_ptr
    import sb_pkg::*;
#(
    parameter int DEPTH = SB_DEPTH_DEF,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] shrink,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] occ,
    output logic             full
);

    // Squashed slots are always the youngest ones, so the tail steps back over them.
    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            head <= head + IDX_W'(pop);
            tail <= tail + IDX_W'(push) - IDX_W'(shrink);
            occ  <= occ + CNT_W'(push) - CNT_W'(pop) - shrink;
        end
    end

    assign full = (occ == CNT_W'(DEPTH));

endmodule

// File: rtl/store_commit_buffer.sv
module store_commit_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH  = SB_DEPTH_DEF,
    parameter int TAG_W  = SB_TAG_W_DEF,
    parameter int ADDR_W = SB_ADDR_W_DEF,
    parameter int DATA_W = SB_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              retire_valid,
    input  logic [TAG_W-1:0]  retire_tag,
    input  logic              squash_valid,
    input  logic [TAG_W-1:0]  squash_tag,
    output logic              drain_valid,
    input  logic              drain_ready,
    output logic [TAG_W-1:0]  drain_tag,
    output logic [ADDR_W-1:0] drain_addr,
    output logic [DATA_W-1:0] drain_data
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_state_e                   ent_st   [DEPTH];
    logic [DEPTH-1:0][TAG_W-1:0] ent_tag;
    logic [ADDR_W-1:0]           ent_addr [DEPTH];
    logic [DATA_W-1:0]           ent_data [DEPTH];
    logic [DEPTH-1:0]            pend_vec;

    logic [DEPTH-1:0] kill_mask, commit_mask, dup_mask;
    logic             dup_hit;
    logic [IDX_W-1:0] dup_idx;
    logic [CNT_W-1:0] kill_cnt;
    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] occ;
    logic             full;
    logic             alloc_fire, push, drain_fire, born_done;

    for (genvar i = 0; i < DEPTH; i++) begin : g_pend
        assign pend_vec[i] = (ent_st[i] == SB_PEND);
    end

    sb_tag_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
        .pend_vec     (pend_vec),
        .ent_tag      (ent_tag),
        .retire_valid (retire_valid),
        .retire_tag   (retire_tag),
        .squash_valid (squash_valid),
        .squash_tag   (squash_tag),
        .alloc_tag    (alloc_tag),
        .kill_mask    (kill_mask),
        .commit_mask  (commit_mask),
        .dup_mask     (dup_mask),
        .dup_hit      (dup_hit),
        .dup_idx      (dup_idx),
        .kill_cnt     (kill_cnt)
    );

    // A store is refused while a squash is in progress. When the buffer is
    // full, a retried store is still taken because it fits into its old slot.
    assign alloc_ready = !squash_valid && (!full || dup_hit);
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign push        = alloc_fire && !dup_hit;
    assign born_done   = retire_valid && (retire_tag == alloc_tag);

    assign drain_valid = (ent_st[head] == SB_DONE);
    assign drain_fire  = drain_valid && drain_ready;
    assign drain_tag   = ent_tag[head];
    assign drain_addr  = ent_addr[head];
    assign drain_data  = ent_data[head];

    sb_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .pop    (drain_fire),
        .shrink (kill_cnt),
        .head   (head),
        .tail   (tail),
        .occ    (occ),
        .full   (full)
    );

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                ent_st[i] <= SB_FREE;
            end else if (push && (tail == IDX_W'(i))) begin
                ent_st[i] <= born_done ? SB_DONE : SB_PEND;
            end else if (drain_fire && (head == IDX_W'(i))) begin
                ent_st[i] <= SB_FREE;
            end else if (kill_mask[i]) begin
                ent_st[i] <= SB_FREE;
            end else if (commit_mask[i]) begin
                ent_st[i] <= SB_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && (tail == IDX_W'(i))) begin
                ent_tag[i]  <= alloc_tag;
                ent_addr[i] <= alloc_addr;
                ent_data[i] <= alloc_data;
            end else if (alloc_fire && dup_hit && (dup_idx == IDX_W'(i))) begin
                ent_addr[i] <= alloc_addr;
                ent_data[i] <= alloc_data;
            end
        end
    end

endmodule

// File: rtl/sb_commit_checker.sv
module sb_commit_checker
    import sb_pkg::*;
#(
    parameter int DEPTH  = SB_DEPTH_DEF,
    parameter int TAG_W  = SB_TAG_W_DEF,
    parameter int ADDR_W = SB_ADDR_W_DEF,
    parameter int DATA_W = SB_DATA_W_DEF,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        alloc_valid,
    input logic                        alloc_ready,
    input logic                        squash_valid,
    input logic [TAG_W-1:0]            squash_tag,
    input logic                        drain_valid,
    input logic                        drain_ready,
    input logic [TAG_W-1:0]            drain_tag,
    input logic [ADDR_W-1:0]           drain_addr,
    input logic [DATA_W-1:0]           drain_data,
    input logic [CNT_W-1:0]            occ,
    input logic [DEPTH-1:0]            pend_vec,
    input logic [DEPTH-1:0][TAG_W-1:0] ent_tag
);

    logic             sq_q;
    logic [TAG_W-1:0] sq_tag_q;
    logic             stale_after_sq;
    logic             twin_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q     <= 1'b0;
            sq_tag_q <= '0;
        end else begin
            sq_q     <= squash_valid;
            sq_tag_q <= squash_tag;
        end
    end

    always_comb begin
        stale_after_sq = 1'b0;
        twin_pending   = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pend_vec[i] && tag_not_older(32'(ent_tag[i]), 32'(sq_tag_q), TAG_W))
                stale_after_sq = 1'b1;
            for (int j = i + 1; j < DEPTH; j++) begin
                if (pend_vec[i] && pend_vec[j] && (ent_tag[i] == ent_tag[j]))
                    twin_pending = 1'b1;
            end
        end
    end

    p_drain_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && !drain_ready) |=>
            (drain_valid && $stable(drain_tag) && $stable(drain_addr) && $stable(drain_data)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    p_full_no_grow_r5: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH) && alloc_valid && alloc_ready) |=>
            (occ == $past(occ) - CNT_W'($past(drain_valid && drain_ready))));

    p_squash_clean_r6: assert property (@(posedge clk) disable iff (rst)
        sq_q |-> !stale_after_sq);

    p_no_twin_r7: assert property (@(posedge clk) disable iff (rst)
        !twin_pending);

endmodule

bind store_commit_buffer sb_commit_checker #(
    .DEPTH  (DEPTH),
    .TAG_W  (TAG_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/store_commit_buffer_tb.sv
module store_commit_buffer_tb;

    localparam int DEPTH  = 4;
    localparam int TAG_W  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              alloc_valid, alloc_ready;
    logic [TAG_W-1:0]  alloc_tag;
    logic [ADDR_W-1:0] alloc_addr;
    logic [DATA_W-1:0] alloc_data;
    logic              retire_valid, squash_valid;
    logic [TAG_W-1:0]  retire_tag, squash_tag;
    logic              drain_valid, drain_ready;
    logic [TAG_W-1:0]  drain_tag;
    logic [ADDR_W-1:0] drain_addr;
    logic [DATA_W-1:0] drain_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    store_commit_buffer #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .alloc_addr(alloc_addr), .alloc_data(alloc_data),
        .retire_valid(retire_valid), .retire_tag(retire_tag),
        .squash_valid(squash_valid), .squash_tag(squash_tag),
        .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_tag(drain_tag),
        .drain_addr(drain_addr), .drain_data(drain_data)
    );

    typedef struct packed {
        logic       av;  logic [3:0] at; logic [7:0] ad;
        logic       rv;  logic [3:0] rt;
        logic       sv;  logic [3:0] st;
        logic       dr;
        logic       ear; logic       edv; logic [3:0] edt; logic [7:0] edd;
    } vec_t;

    localparam vec_t VEC [23] = '{
        '{1'b1, 4'd1, 8'h11, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}, // R2 alloc 1
        '{1'b1, 4'd2, 8'h22, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}, // R2 alloc 2
        '{1'b0, 4'd0, 8'h00, 1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00}, // R3 retire 1
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd1, 8'h11}, // R4 stalled
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd1, 8'h11}, // R4 held
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 4'd1, 8'h11}, // R4 drain 1
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}, // R2 2 pending
        '{1'b1, 4'd2, 8'h2A, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}, // R7 retry 2
        '{1'b0, 4'd0, 8'h00, 1'b1, 4'd2, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}, // R3 retire 2
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 4'd2, 8'h2A}, // R7 new data
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}, // R7 no copy
        '{1'b1, 4'd3, 8'h33, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd4, 8'h44, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd5, 8'h50, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd6, 8'h66, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd7, 8'h77, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h00}, // R5 full
        '{1'b1, 4'd5, 8'h55, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}, // R5 retry ok
        '{1'b0, 4'd0, 8'h00, 1'b1, 4'd3, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h00}, // R5 full
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 1'b0, 1'b1, 4'd3, 8'h33}, // R6 squash 5
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 4'd3, 8'h33}, // R4 drain 3
        '{1'b0, 4'd0, 8'h00, 1'b1, 4'd4, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 4'd4, 8'h44}, // R4 drain 4
        '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}  // R6 5,6 gone
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_tag = '0; alloc_addr = '0; alloc_data = '0;
        retire_valid = 0; retire_tag = '0;
        squash_valid = 0; squash_tag = '0;
        drain_ready = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic alloc(input logic [3:0] t, input logic [7:0] d);
        alloc_valid = 1; alloc_tag = t; alloc_addr = 16'h1200 | 16'(t); alloc_data = d;
    endtask

    task automatic expect_drain(input string req, input bit v, input logic [3:0] t);
        check(drain_valid == v, req, "drain_valid", 32'(drain_valid), 32'(v));
        if (v) check(drain_tag == t, req, "drain_tag", 32'(drain_tag), 32'(t));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        do_reset();

        // R1: state straight after reset
        #1;
        check(alloc_ready == 1'b1, "R1", "alloc_ready", 32'(alloc_ready), 32'd1);
        check(drain_valid == 1'b0, "R1", "drain_valid", 32'(drain_valid), 32'd0);

        // Table walk
        for (int r = 0; r < 23; r++) begin
            @(negedge clk);
            idle();
            alloc_valid = VEC[r].av; alloc_tag = VEC[r].at;
            alloc_addr = 16'h1200 | 16'(VEC[r].at); alloc_data = VEC[r].ad;
            retire_valid = VEC[r].rv; retire_tag = VEC[r].rt;
            squash_valid = VEC[r].sv; squash_tag = VEC[r].st;
            drain_ready = VEC[r].dr;
            #1;
            check(alloc_ready == VEC[r].ear, $sformatf("table row %0d", r), "alloc_ready",
                  32'(alloc_ready), 32'(VEC[r].ear));
            check(drain_valid == VEC[r].edv, $sformatf("table row %0d", r), "drain_valid",
                  32'(drain_valid), 32'(VEC[r].edv));
            if (VEC[r].edv) begin
                check(drain_tag == VEC[r].edt, $sformatf("table row %0d", r), "drain_tag",
                      32'(drain_tag), 32'(VEC[r].edt));
                check(drain_data == VEC[r].edd, $sformatf("table row %0d", r), "drain_data",
                      32'(drain_data), 32'(VEC[r].edd));
            end
        end

        // R3: retire in the allocation cycle, address and data carried through (R4)
        do_reset();
        alloc(4'd9, 8'h5A); retire_valid = 1; retire_tag = 4'd9;
        @(negedge clk); idle(); drain_ready = 1; #1;
        expect_drain("R3", 1'b1, 4'd9);
        check(drain_addr == 16'h1209, "R4", "drain_addr", 32'(drain_addr), 32'h1209);
        check(drain_data == 8'h5A, "R4", "drain_data", 32'(drain_data), 32'h5A);
        @(negedge clk); idle(); #1;
        expect_drain("R4", 1'b0, 4'd0);

        // R6: squash across tag wrap keeps the older tag 14 only
        do_reset();
        alloc(4'd14, 8'hE0); @(negedge clk); idle();
        alloc(4'd15, 8'hF0); @(negedge clk); idle();
        alloc(4'd0,  8'h00); @(negedge clk); idle();
        alloc(4'd1,  8'h01); @(negedge clk); idle();
        squash_valid = 1; squash_tag = 4'd15; alloc(4'd2, 8'h02); #1;
        check(alloc_ready == 1'b0, "R6", "alloc_ready in squash", 32'(alloc_ready), 32'd0);
        @(negedge clk); idle();
        retire_valid = 1; retire_tag = 4'd15;            // R8: squashed tag retires
        @(negedge clk); idle(); drain_ready = 1; #1;
        expect_drain("R8", 1'b0, 4'd0);
        @(negedge clk); idle(); retire_valid = 1; retire_tag = 4'd14;
        @(negedge clk); idle(); drain_ready = 1; #1;
        expect_drain("R6", 1'b1, 4'd14);
        @(negedge clk); idle(); retire_valid = 1; retire_tag = 4'd0; drain_ready = 1;
        @(negedge clk); idle(); drain_ready = 1; #1;
        expect_drain("R8", 1'b0, 4'd0);
        check(alloc_ready == 1'b1, "R6", "alloc_ready empty", 32'(alloc_ready), 32'd1);

        // R6: a committed entry at the squash tag survives, the younger pending one does not
        do_reset();
        alloc(4'd2, 8'h20); @(negedge clk); idle();
        alloc(4'd3, 8'h30); retire_valid = 1; retire_tag = 4'd2;
        @(negedge clk); idle(); squash_valid = 1; squash_tag = 4'd2; #1;
        expect_drain("R6", 1'b1, 4'd2);
        @(negedge clk); idle(); drain_ready = 1; #1;
        expect_drain("R6", 1'b1, 4'd2);
        @(negedge clk); idle(); retire_valid = 1; retire_tag = 4'd3; drain_ready = 1;
        @(negedge clk); idle(); drain_ready = 1; #1;
        expect_drain("R6", 1'b0, 4'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule